// File: doc/BRIEF.md
# Multi-Core Interrupt Routing Controller

This block takes a wide vector of level-sensitive interrupt sources and steers each one to one of several parent interrupt lines on one of several cores. Software programs it through a 32-bit register bus with byte enables. Per-source enable bits decide whether a source may reach any core. A route byte shared by each group of 32 sources selects the parent line. A core byte for each source selects the target core. Per-core status registers record which sources are currently asserting toward the core that reads them.

A source that is asserted and enabled sets its status bit in the same clock edge that samples the input. That status bit keeps the chosen parent line high until the input falls, the source is disabled, or the core clears the bit by writing 1. Changing the enable or the core byte of a source that is still asserted takes effect at once: its assertion is raised, dropped or moved to the new core. Route-byte writes leave assertions that are already latched on their old line. A configuration word selects whether route and core bytes are read as binary numbers or as lowest-set-bit one-hot codes. Two further register ranges are plain storage.

Top module: `eir_route_ctrl`

## Requirements
- R1: After reset all parent lines are low and every register reads zero; a bus response (`bus_rvalid`, `bus_rdata`, `bus_err`) appears one cycle after each request.
- R2: With configuration bit 0 clear, the parent line of a group is the index of the lowest set bit of its route byte; a zero byte or an index of NUM_LINE or more selects line 0.
- R3: With configuration bit 0 set, the route byte is a binary line number taken modulo NUM_LINE.
- R4: With configuration bit 1 clear, the target core of a source is the index of the lowest set bit of its core byte; a zero byte or an index of NUM_CORE or more selects core 0.
- R5: With configuration bit 1 set, the core byte is a binary core number taken modulo NUM_CORE.
- R6: A source that rises while its enable bit is 1 sets its status bit at its target core on the edge that samples it. A source whose enable bit is 0 sets nothing. A source that falls clears its status bit.
- R7: Output `parent_irq[c*NUM_LINE+l]` is high while at least one status bit latched for core c and line l is set. It falls only when the last such bit clears.
- R8: Status words are write-1-to-clear and act only on bits held by the core given on `bus_core`; writing 1 to a bit that is clear, or to another core's bit, changes nothing.
- R9: Writing an enable bit from 0 to 1 while its source is asserted raises the source. Writing it from 1 to 0 drops the source.
- R10: Writing a core byte so that an asserted, enabled source decodes to a different core removes its status at the old core and sets it at the new one in the same edge.
- R11: Writing a route byte does not move status bits that are already set; only bits set later use the new line.
- R12: The node-type words and the bounce words read back what was written and never affect the parent lines.
- R13: A request to an unmapped word address returns zero data and raises `bus_err` for exactly the one response cycle.
- R14: Only bytes whose `bus_be` bit is 1 are written. With default parameters the word map is: configuration 0, node-type 4..7, route 8..9, enable 16..23, bounce 24..31, status 32..39, core 64..127. Source s uses bit s%32 of enable or status word s/32. Group g uses byte g%4 of route word g/4. Source s uses byte s%4 of core word s/4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Level-sensitive source inputs |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_core | input | CID_W | Index of the core issuing the access |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Response strobe, one cycle after a request |
| bus_rdata | output | 32 | Read data (zero for writes and unmapped reads) |
| bus_err | output | 1 | Unmapped-address flag, valid with `bus_rvalid` |
| parent_irq | output | NUM_CORE*NUM_LINE | Parent lines, index core*NUM_LINE+line |

## Verification
The hardest case to reach is a source whose status is already latched when a register write changes the source's context. This covers a core byte rewritten under a pending source, a route byte rewritten under a latched bit, and an enable toggled while the input stays high. The directed tasks first raise a source and check its parent line. They then issue the disturbing write while the input stays high and check, in the response cycle of that write, where the assertion sits. A second source that shares or no longer shares the line then shows whether the line drops only with the last holder.

// File: rtl/eir_pkg.sv
package eir_pkg;

   localparam int GRP_SIZE = 32;
   localparam int WORD_W   = 32;

   typedef enum logic [2:0] {
      RG_NONE, RG_CFG, RG_NODE, RG_ROUTE, RG_EN, RG_BNC, RG_STAT, RG_CORE
   } region_e;

   function automatic logic [WORD_W-1:0] be_mask(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [3:0]        be);
      return (old_w & ~be_mask(be)) | (new_w & be_mask(be));
   endfunction

endpackage

// File: rtl/eir_sel_dec.sv
module eir_sel_dec #(
   parameter  int NUM_SEL = 4,
   localparam int IW      = $clog2(NUM_SEL)
) (
   input  logic          mode_bin,
   input  logic [7:0]    code,
   output logic [IW-1:0] idx
);

   if (NUM_SEL < 2 || NUM_SEL > 8 || (NUM_SEL & (NUM_SEL - 1)) != 0) begin : g_bad_sel
      $error("eir_sel_dec: NUM_SEL must be a power of two between 2 and 8");
   end

   logic [3:0]    low;
   logic [IW-1:0] oh_idx;

   always_comb begin
      low = 4'd0;
      for (int i = 7; i >= 0; i--) begin
         if (code[i]) low = 4'(i);
      end
      oh_idx = (int'(low) < NUM_SEL) ? IW'(low) : '0;
   end

   assign idx = mode_bin ? code[IW-1:0] : oh_idx;

endmodule

// File: rtl/eir_src_cell.sv
module eir_src_cell #(
   parameter int CID_W = 2,
   parameter int LID_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_lvl,
   input  logic             en_prev,
   input  logic             en_next,
   input  logic             move_req,
   input  logic             w1c_req,
   input  logic [CID_W-1:0] req_core,
   input  logic [CID_W-1:0] new_core,
   input  logic [LID_W-1:0] new_line,
   output logic             stat,
   output logic             own_bit,
   output logic [CID_W-1:0] hold_core,
   output logic [LID_W-1:0] hold_line
);

   logic raw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q     <= 1'b0;
         stat      <= 1'b0;
         hold_core <= '0;
         hold_line <= '0;
      end else begin
         raw_q <= irq_lvl;
         if (!irq_lvl || !en_next) begin
            stat <= 1'b0;
         end else if (!raw_q || !en_prev || move_req) begin
            stat      <= 1'b1;
            hold_core <= new_core;
            hold_line <= new_line;
         end else if (w1c_req && hold_core == req_core) begin
            stat <= 1'b0;
         end
      end
   end

   assign own_bit = stat && (hold_core == req_core);

endmodule

// File: rtl/eir_line_merge.sv
module eir_line_merge #(
   parameter  int NUM_SRC  = 256,
   parameter  int NUM_CORE = 4,
   parameter  int NUM_LINE = 4,
   localparam int CID_W    = $clog2(NUM_CORE),
   localparam int LID_W    = $clog2(NUM_LINE)
) (
   input  logic [NUM_SRC-1:0]          stat,
   input  logic [NUM_SRC*CID_W-1:0]    core_f,
   input  logic [NUM_SRC*LID_W-1:0]    line_f,
   output logic [NUM_CORE*NUM_LINE-1:0] parent
);

   always_comb begin
      parent = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (stat[s]) begin
            parent[int'(core_f[s*CID_W +: CID_W]) * NUM_LINE
                   + int'(line_f[s*LID_W +: LID_W])] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/eir_route_ctrl.sv
module eir_route_ctrl
   import eir_pkg::*;
#(
   parameter  int NUM_SRC  = 256,
   parameter  int NUM_CORE = 4,
   parameter  int NUM_LINE = 4,
   parameter  int NODE_W   = 4,
   parameter  int ADDR_W   = 8,
   localparam int CID_W    = $clog2(NUM_CORE),
   localparam int LID_W    = $clog2(NUM_LINE),
   localparam int NPAR     = NUM_CORE * NUM_LINE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               bus_req,
   input  logic               bus_wr,
   input  logic [CID_W-1:0]   bus_core,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [3:0]         bus_be,
   input  logic [31:0]        bus_wdata,
   output logic               bus_rvalid,
   output logic [31:0]        bus_rdata,
   output logic               bus_err,
   output logic [NPAR-1:0]    parent_irq
);

   localparam int NGRP    = NUM_SRC / GRP_SIZE;
   localparam int RW      = (NGRP + 3) / 4;
   localparam int CW      = NUM_SRC / 4;
   localparam int A_CFG   = 0;
   localparam int A_NODE  = 4;
   localparam int A_ROUTE = A_NODE + NODE_W;
   localparam int A_EN    = 1 << $clog2(A_ROUTE + RW + 1);
   localparam int A_BNC   = A_EN + NGRP;
   localparam int A_STAT  = A_BNC + NGRP;
   localparam int A_CORE  = 1 << $clog2(A_STAT + NGRP + 1);
   localparam int AW_NEED = $clog2(A_CORE + CW);

   if (NUM_SRC % GRP_SIZE != 0) begin : g_bad_src
      $error("eir_route_ctrl: NUM_SRC must be a multiple of 32");
   end
   if (ADDR_W < AW_NEED) begin : g_bad_addr
      $error("eir_route_ctrl: ADDR_W too small for the register map");
   end

   // ---------------- register state ----------------
   logic [1:0]           cfg_q;
   logic [NODE_W*32-1:0] node_q;
   logic [RW*32-1:0]     route_q;
   logic [NUM_SRC-1:0]   en_q, en_d;
   logic [NUM_SRC-1:0]   bnc_q;
   logic [CW*32-1:0]     core_q, core_d;
   logic [NUM_SRC-1:0]   w1c_vec;
   logic [NUM_SRC-1:0]   rd_stat;

   // ---------------- address decode ----------------
   region_e rg;
   int      off;
   int      a;
   logic    wr;

   assign wr = bus_req && bus_wr;

   always_comb begin
      a   = int'(bus_addr);
      rg  = RG_NONE;
      off = 0;
      if (a == A_CFG) begin
         rg = RG_CFG;
      end else if (a >= A_NODE && a < A_NODE + NODE_W) begin
         rg = RG_NODE;  off = a - A_NODE;
      end else if (a >= A_ROUTE && a < A_ROUTE + RW) begin
         rg = RG_ROUTE; off = a - A_ROUTE;
      end else if (a >= A_EN && a < A_EN + NGRP) begin
         rg = RG_EN;    off = a - A_EN;
      end else if (a >= A_BNC && a < A_BNC + NGRP) begin
         rg = RG_BNC;   off = a - A_BNC;
      end else if (a >= A_STAT && a < A_STAT + NGRP) begin
         rg = RG_STAT;  off = a - A_STAT;
      end else if (a >= A_CORE && a < A_CORE + CW) begin
         rg = RG_CORE;  off = a - A_CORE;
      end
   end

   // ---------------- next-state of registers that feed the cells ----------------
   always_comb begin
      en_d    = en_q;
      core_d  = core_q;
      w1c_vec = '0;
      if (wr && rg == RG_EN)
         en_d[off*32 +: 32] = merge_word(en_q[off*32 +: 32], bus_wdata, bus_be);
      if (wr && rg == RG_CORE)
         core_d[off*32 +: 32] = merge_word(core_q[off*32 +: 32], bus_wdata, bus_be);
      if (wr && rg == RG_STAT)
         w1c_vec[off*32 +: 32] = bus_wdata & be_mask(bus_be);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         node_q  <= '0;
         route_q <= '0;
         en_q    <= '0;
         bnc_q   <= '0;
         core_q  <= '0;
      end else begin
         en_q   <= en_d;
         core_q <= core_d;
         if (wr && rg == RG_CFG && bus_be[0])
            cfg_q <= bus_wdata[1:0];
         if (wr && rg == RG_NODE)
            node_q[off*32 +: 32] <= merge_word(node_q[off*32 +: 32], bus_wdata, bus_be);
         if (wr && rg == RG_ROUTE)
            route_q[off*32 +: 32] <= merge_word(route_q[off*32 +: 32], bus_wdata, bus_be);
         if (wr && rg == RG_BNC)
            bnc_q[off*32 +: 32] <= merge_word(bnc_q[off*32 +: 32], bus_wdata, bus_be);
      end
   end

   // ---------------- line decode per group ----------------
   logic [LID_W-1:0] grp_line [NGRP];

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      eir_sel_dec #(.NUM_SEL(NUM_LINE)) line_dec_i (
         .mode_bin (cfg_q[0]),
         .code     (route_q[g*8 +: 8]),
         .idx      (grp_line[g])
      );
   end

   // ---------------- per-source cells ----------------
   logic [NUM_SRC-1:0]       stat_v;
   logic [NUM_SRC*CID_W-1:0] hold_core_f;
   logic [NUM_SRC*LID_W-1:0] hold_line_f;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [CID_W-1:0] core_new, core_old;

      eir_sel_dec #(.NUM_SEL(NUM_CORE)) new_dec_i (
         .mode_bin (cfg_q[1]),
         .code     (core_d[s*8 +: 8]),
         .idx      (core_new)
      );
      eir_sel_dec #(.NUM_SEL(NUM_CORE)) old_dec_i (
         .mode_bin (cfg_q[1]),
         .code     (core_q[s*8 +: 8]),
         .idx      (core_old)
      );

      eir_src_cell #(.CID_W(CID_W), .LID_W(LID_W)) cell_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .irq_lvl   (irq_in[s]),
         .en_prev   (en_q[s]),
         .en_next   (en_d[s]),
         .move_req  (core_new != core_old),
         .w1c_req   (w1c_vec[s]),
         .req_core  (bus_core),
         .new_core  (core_new),
         .new_line  (grp_line[s / GRP_SIZE]),
         .stat      (stat_v[s]),
         .own_bit   (rd_stat[s]),
         .hold_core (hold_core_f[s*CID_W +: CID_W]),
         .hold_line (hold_line_f[s*LID_W +: LID_W])
      );
   end

   eir_line_merge #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_LINE(NUM_LINE)) merge_i (
      .stat   (stat_v),
      .core_f (hold_core_f),
      .line_f (hold_line_f),
      .parent (parent_irq)
   );

   // ---------------- read path and response ----------------
   logic [31:0] rd_val;

   always_comb begin
      unique case (rg)
         RG_CFG:   rd_val = {30'd0, cfg_q};
         RG_NODE:  rd_val = node_q[off*32 +: 32];
         RG_ROUTE: rd_val = route_q[off*32 +: 32];
         RG_EN:    rd_val = en_q[off*32 +: 32];
         RG_BNC:   rd_val = bnc_q[off*32 +: 32];
         RG_STAT:  rd_val = rd_stat[off*32 +: 32];
         RG_CORE:  rd_val = core_q[off*32 +: 32];
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_err    <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_req;
         bus_err    <= bus_req && (rg == RG_NONE);
         bus_rdata  <= (bus_req && !bus_wr) ? rd_val : '0;
      end
   end

endmodule

// File: rtl/eir_chk.sv
module eir_chk #(
   parameter int NUM_SRC = 256,
   parameter int NPAR    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] irq_in,
   input logic               bus_req,
   input logic               bus_rvalid,
   input logic [31:0]        bus_rdata,
   input logic               bus_err,
   input logic [NPAR-1:0]    parent_irq
);

   // R13: error flag only comes with a response
   a_r13_err_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> bus_rvalid);

   // R13: unmapped access returns zero data
   a_r13_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == '0));

   // R1: a response follows a request by one cycle
   a_r1_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_req));

   // R6: a parent line can only rise if some source input was high
   a_r6_rise_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|parent_irq) |-> $past(|irq_in));

   // R7: with every input low, all parent lines are low one edge later
   a_r7_quiet_inputs: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in == '0) |=> (parent_irq == '0));

endmodule

bind eir_route_ctrl eir_chk #(.NUM_SRC(NUM_SRC), .NPAR(NPAR)) chk_i (.*);

// File: tb/eir_route_ctrl_tb_top.sv
`timescale 1ns/1ps
module eir_route_ctrl_tb_top;

   localparam int NS = 256;
   localparam int NC = 4;
   localparam int NL = 4;

   localparam int A_CFG = 0, A_NODE = 4, A_ROUTE = 8, A_EN = 16;
   localparam int A_BNC = 24, A_STAT = 32, A_CORE = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq_in = '0;
   logic          bus_req = 1'b0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_core = '0;
   logic [7:0]    bus_addr = '0;
   logic [3:0]    bus_be = '0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_rvalid;
   logic [31:0]   bus_rdata;
   logic          bus_err;
   logic [15:0]   parent_irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   eir_route_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_req(bus_req), .bus_wr(bus_wr), .bus_core(bus_core),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .parent_irq(parent_irq)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic bus_write(input int core, input int addr, input logic [3:0] be,
                            input logic [31:0] d, output logic err);
      bus_req = 1'b1; bus_wr = 1'b1; bus_core = 2'(core);
      bus_addr = 8'(addr); bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
      err = bus_err;
   endtask

   task automatic wr(input int core, input int addr, input logic [3:0] be, input logic [31:0] d);
      logic e;
      bus_write(core, addr, be, d, e);
   endtask

   task automatic bus_read(input int core, input int addr,
                           output logic [31:0] d, output logic err);
      bus_req = 1'b1; bus_wr = 1'b0; bus_core = 2'(core); bus_addr = 8'(addr);
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata; err = bus_err;
   endtask

   task automatic set_src(input int s, input logic v);
      irq_in[s] = v;
      @(negedge clk);
   endtask

   function automatic logic [31:0] pbit(input int c, input int l);
      return 32'(1) << (c * NL + l);
   endfunction

   task automatic chk_par(input string req, input logic [31:0] exp);
      check(req, "parent_irq", {16'd0, parent_irq}, exp);
   endtask

   task automatic chk_rd(input string req, input int core, input int addr, input logic [31:0] exp);
      logic [31:0] d;
      logic        e;
      bus_read(core, addr, d, e);
      check(req, $sformatf("read @%0d", addr), d, exp);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk_par("R1", 0);
      chk_rd("R1", 0, A_CFG, 0);
      chk_rd("R1", 0, A_EN, 0);
      chk_rd("R1", 0, A_CORE, 0);
   endtask

   task automatic t_basic();
      wr(0, A_ROUTE, 4'b0001, 32'h04);          // group 0 -> line 2
      wr(0, A_CORE, 4'b1000, 32'h0200_0000);    // src 3 -> core 1
      wr(0, A_EN, 4'b1111, 32'h08);             // enable src 3
      set_src(3, 1'b1);
      chk_par("R6", pbit(1, 2));                // R2, R4 one-hot decode
      chk_rd("R6", 1, A_STAT, 32'h08);
      chk_rd("R8", 0, A_STAT, 32'h0);
      set_src(5, 1'b1);                         // disabled source
      chk_par("R6", pbit(1, 2));
      chk_rd("R6", 0, A_STAT, 32'h0);
      set_src(5, 1'b0);
      set_src(3, 1'b0);
      chk_par("R6", 0);
      chk_rd("R6", 1, A_STAT, 32'h0);
   endtask

   task automatic t_onehot_default();
      wr(0, A_ROUTE, 4'b0010, 32'h3000);        // group 1 byte 0x30 -> line 0
      wr(0, A_CORE + 10, 4'b0001, 32'h10);      // src 40 byte 0x10 -> core 0
      wr(0, A_EN + 1, 4'b1111, 32'h100);        // enable src 40
      set_src(40, 1'b1);
      chk_par("R2", pbit(0, 0));
      chk_rd("R4", 0, A_STAT + 1, 32'h100);
      set_src(40, 1'b0);
      chk_par("R4", 0);
   endtask

   task automatic t_binary();
      wr(0, A_CFG, 4'b0001, 32'h3);
      wr(0, A_ROUTE, 4'b0100, 32'h0003_0000);   // group 2 -> line 3
      wr(0, A_CORE + 17, 4'b0100, 32'h0002_0000); // src 70 -> core 2
      wr(0, A_EN + 2, 4'b1111, 32'h40);
      set_src(70, 1'b1);
      chk_par("R3", pbit(2, 3));
      chk_rd("R5", 2, A_STAT + 2, 32'h40);
      set_src(70, 1'b0);
      wr(0, A_CFG, 4'b0001, 32'h0);
      chk_par("R5", 0);
   endtask

   task automatic t_shared();
      wr(0, A_CORE + 1, 4'b0001, 32'h02);       // src 4 -> core 1
      wr(0, A_EN, 4'b1111, 32'h18);
      set_src(3, 1'b1);
      set_src(4, 1'b1);
      chk_par("R7", pbit(1, 2));
      set_src(3, 1'b0);
      chk_par("R7", pbit(1, 2));
      set_src(4, 1'b0);
      chk_par("R7", 0);
   endtask

   task automatic t_w1c();
      set_src(3, 1'b1);
      chk_par("R8", pbit(1, 2));
      wr(0, A_STAT, 4'b1111, 32'h08);           // wrong core
      chk_par("R8", pbit(1, 2));
      chk_rd("R8", 1, A_STAT, 32'h08);
      wr(1, A_STAT, 4'b1111, 32'h10);           // bit not set
      chk_par("R8", pbit(1, 2));
      wr(1, A_STAT, 4'b1111, 32'h08);
      chk_par("R8", 0);
      chk_rd("R8", 1, A_STAT, 32'h0);
      set_src(3, 1'b0);
   endtask

   task automatic t_enable();
      wr(0, A_EN, 4'b1111, 32'h10);
      set_src(3, 1'b1);
      chk_par("R9", 0);
      wr(0, A_EN, 4'b1111, 32'h18);
      chk_par("R9", pbit(1, 2));
      wr(0, A_EN, 4'b1111, 32'h10);
      chk_par("R9", 0);
      wr(0, A_EN, 4'b1111, 32'h18);
      chk_par("R9", pbit(1, 2));
      set_src(3, 1'b0);
      chk_par("R9", 0);
   endtask

   task automatic t_move();
      set_src(3, 1'b1);
      wr(0, A_CORE, 4'b1000, 32'h0100_0000);    // src 3 -> core 0
      chk_par("R10", pbit(0, 2));
      chk_rd("R10", 0, A_STAT, 32'h08);
      chk_rd("R10", 1, A_STAT, 32'h0);
      wr(0, A_CORE, 4'b1000, 32'h0200_0000);    // back to core 1
      chk_par("R10", pbit(1, 2));
      set_src(3, 1'b0);
      chk_par("R10", 0);
   endtask

   task automatic t_route();
      set_src(3, 1'b1);
      wr(0, A_ROUTE, 4'b0001, 32'h08);          // group 0 -> line 3
      chk_par("R11", pbit(1, 2));
      set_src(4, 1'b1);
      chk_par("R11", pbit(1, 2) | pbit(1, 3));
      set_src(3, 1'b0);
      chk_par("R11", pbit(1, 3));
      set_src(4, 1'b0);
      chk_par("R11", 0);
      wr(0, A_ROUTE, 4'b0001, 32'h04);
   endtask

   task automatic t_storage();
      wr(0, A_NODE + 1, 4'b1111, 32'hA5A5_1234);
      wr(0, A_BNC + 3, 4'b1111, 32'h5A5A_00FF);
      chk_rd("R12", 0, A_NODE + 1, 32'hA5A5_1234);
      chk_rd("R12", 0, A_BNC + 3, 32'h5A5A_00FF);
      chk_par("R12", 0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      logic        e;
      bus_read(0, 2, d, e);
      check("R13", "err on unmapped read", 32'(e), 1);
      check("R13", "data on unmapped read", d, 0);
      bus_read(0, A_CFG, d, e);
      check("R13", "err on mapped read", 32'(e), 0);
      bus_write(0, 45, 4'b1111, 32'hFFFF_FFFF, e);
      check("R13", "err on unmapped write", 32'(e), 1);
      @(negedge clk);
      check("R13", "err after one cycle", 32'(bus_err), 0);
   endtask

   task automatic t_bytes();
      wr(0, A_EN + 3, 4'b0010, 32'hFFFF_FFFF);
      chk_rd("R14", 0, A_EN + 3, 32'h0000_FF00);
      chk_rd("R14", 0, A_ROUTE, 32'h0003_3004);
      wr(0, A_EN + 3, 4'b1111, 32'h0);
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_onehot_default();
      t_binary();
      t_shared();
      t_w1c();
      t_enable();
      t_move();
      t_route();
      t_storage();
      t_unmapped();
      t_bytes();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule